// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Bank

This block watches a bank of 32 asynchronous external lines and turns selected transitions on them into interrupt requests. Each line is first brought into the clock domain, and it is then either an edge line or a direct line. On an edge line the block compares the line with its value one clock earlier, checks that edge against the line's rising and falling selects, and latches it into a rising or falling pending flag. A direct line skips this and feeds its level straight to the output through the interrupt mask. Software can also force a line pending without any edge.

A small memory-mapped port (write strobe, address, write data, combinational read data) gives software access to the select, mask, software-trigger and pending registers, plus a read-only line-type register. The combined request `irq_o` comes from a two-state machine. State IRQ_QUIET moves to IRQ_RAISED on the clock after any unmasked source appears. IRQ_RAISED returns to IRQ_QUIET on the clock after the last unmasked source is gone. `irq_o` is high exactly while the machine is in IRQ_RAISED. A separate per-line event output gives a one-clock pulse for each latched event on lines enabled in the event mask.

Top module: `extint_bank`

## Requirements
- R1: After reset, every writable register reads 0, `irq_o` and `evt_o` are 0, and the line-type register at offset 0x3EC reads the `EDGE_LINES` parameter (bit n set = line n is an edge line, clear = direct line).
- R2: A 0-to-1 change on edge line n, with bit n of the rising-select register (0x00) set, sets bit n of the rising-pending register (0x0C). It is readable on the third rising clock edge after the line change is first sampled.
- R3: A 1-to-0 change on edge line n, with bit n of the falling-select register (0x04) set, sets bit n of the falling-pending register (0x10). With both selects set, the line latches on either edge.
- R4: A transition on a line whose matching select bit is clear leaves both pending registers unchanged.
- R5: Writing a 1 to a bit of either pending register clears that bit on the write clock edge. Bits written as 0 keep their value, and without a write a pending bit never clears.
- R6: If an edge sets a pending bit in the same clock edge as a write-one clear of that bit, the bit stays set.
- R7: Writing to the software-trigger register (0x08) sets the rising-pending bit of every edge line written as 1. Bits for direct lines and bits written as 0 are ignored, and the register always reads 0.
- R8: The interrupt mask register (0x80) gates each line's contribution to `irq_o`. A masked line still latches pending but does not raise `irq_o`.
- R9: `evt_o[n]` pulses high for one clock on the edge that latches an event on line n (rising, falling or software trigger) if bit n of the event mask (0x84) was set before that edge.
- R10: Direct lines never latch pending (their pending bits read 0). Their synchronized level ANDed with the interrupt mask drives `irq_o`, one clock after the level is synchronized.
- R11: The request machine moves IRQ_QUIET to IRQ_RAISED one clock after an unmasked source (pending or direct level) exists, and IRQ_RAISED to IRQ_QUIET one clock after none exists. `irq_o` is high only in IRQ_RAISED.
- R12: The select and mask registers read back what was written. Writes to the line-type register are ignored, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 32 | Asynchronous external lines, bit n = line n |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Registered combined interrupt request |
| evt_o | output | 32 | Per-line one-clock event pulses |

## Verification
A pending bit that is lost, or one that gets set by mistake, shows up at the read port on the next access to that pending register. It also shows on `irq_o` one clock later once the line is unmasked. A wrong request-machine state differs from the source set within one clock, and a bad synchronizer or edge history moves or drops a pending bit and an event pulse by a whole cycle. The bench therefore compares `irq_o`, `evt_o` and the read data against a behavioural model on every clock, under directed and random line and write activity. This random traffic includes edges that land on the same clock edge as write-one clears.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
package extint_pkg;
    // register byte offsets; software depends on these positions
    localparam int unsigned OFS_RSEL  = 'h000;
    localparam int unsigned OFS_FSEL  = 'h004;
    localparam int unsigned OFS_SWTRG = 'h008;
    localparam int unsigned OFS_RPND  = 'h00C;
    localparam int unsigned OFS_FPND  = 'h010;
    localparam int unsigned OFS_IMSK  = 'h080;
    localparam int unsigned OFS_EMSK  = 'h084;
    localparam int unsigned OFS_LTYPE = 'h3EC;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/extint_sync.sv
`timescale 1ns/1ps
module extint_sync #(
    parameter int unsigned NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_i,
    output logic [NLINES-1:0] lvl_o,
    output logic [NLINES-1:0] rise_o,
    output logic [NLINES-1:0] fall_o
);
    logic [NLINES-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl_o  = sync_q;
    assign rise_o = sync_q & ~prev_q;
    assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/extint_pend.sv
`timescale 1ns/1ps
module extint_pend #(
    parameter int unsigned          NLINES     = 32,
    parameter logic [NLINES-1:0]    EDGE_LINES = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] rise_i,
    input  logic [NLINES-1:0] fall_i,
    input  logic [NLINES-1:0] rsel_i,
    input  logic [NLINES-1:0] fsel_i,
    input  logic [NLINES-1:0] sw_i,
    input  logic [NLINES-1:0] rclr_i,
    input  logic [NLINES-1:0] fclr_i,
    input  logic [NLINES-1:0] emask_i,
    output logic [NLINES-1:0] rpend_o,
    output logic [NLINES-1:0] fpend_o,
    output logic [NLINES-1:0] evt_o
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        if (EDGE_LINES[i]) begin : g_edge
            logic r_q, f_q, e_q, set_r, set_f;
            assign set_r = (rise_i[i] & rsel_i[i]) | sw_i[i];
            assign set_f = fall_i[i] & fsel_i[i];
            // a new event beats a clear in the same cycle
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r_q <= 1'b0;
                    f_q <= 1'b0;
                    e_q <= 1'b0;
                end else begin
                    r_q <= (r_q & ~rclr_i[i]) | set_r;
                    f_q <= (f_q & ~fclr_i[i]) | set_f;
                    e_q <= (set_r | set_f) & emask_i[i];
                end
            end
            assign rpend_o[i] = r_q;
            assign fpend_o[i] = f_q;
            assign evt_o[i]   = e_q;
        end else begin : g_direct
            logic unused_bits;
            assign unused_bits = ^{rise_i[i], fall_i[i], rsel_i[i], fsel_i[i],
                                   sw_i[i], rclr_i[i], fclr_i[i], emask_i[i]};
            assign rpend_o[i] = 1'b0;
            assign fpend_o[i] = 1'b0;
            assign evt_o[i]   = 1'b0;
        end
    end
endmodule

// File: rtl/extint_irq_fsm.sv
`timescale 1ns/1ps
module extint_irq_fsm
    import extint_pkg::*;
#(
    parameter int unsigned       NLINES     = 32,
    parameter logic [NLINES-1:0] EDGE_LINES = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] rpend_i,
    input  logic [NLINES-1:0] fpend_i,
    input  logic [NLINES-1:0] imask_i,
    input  logic [NLINES-1:0] lvl_i,
    output logic              irq_o
);
    irq_state_t state_q, state_d;
    logic       any_src;

    assign any_src = |(((rpend_i | fpend_i) & imask_i) | (lvl_i & imask_i & ~EDGE_LINES));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_src)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_src) state_d = IRQ_QUIET;
            default:                  state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/extint_bank.sv
`timescale 1ns/1ps
module extint_bank
    import extint_pkg::*;
#(
    parameter int unsigned       NLINES     = 32,
    parameter int unsigned       ADDR_W     = 12,
    parameter logic [NLINES-1:0] EDGE_LINES = 32'h0FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    output logic              irq_o,
    output logic [NLINES-1:0] evt_o
);
    localparam logic [ADDR_W-1:0] A_RSEL  = ADDR_W'(OFS_RSEL);
    localparam logic [ADDR_W-1:0] A_FSEL  = ADDR_W'(OFS_FSEL);
    localparam logic [ADDR_W-1:0] A_SWTRG = ADDR_W'(OFS_SWTRG);
    localparam logic [ADDR_W-1:0] A_RPND  = ADDR_W'(OFS_RPND);
    localparam logic [ADDR_W-1:0] A_FPND  = ADDR_W'(OFS_FPND);
    localparam logic [ADDR_W-1:0] A_IMSK  = ADDR_W'(OFS_IMSK);
    localparam logic [ADDR_W-1:0] A_EMSK  = ADDR_W'(OFS_EMSK);
    localparam logic [ADDR_W-1:0] A_LTYPE = ADDR_W'(OFS_LTYPE);

    logic [NLINES-1:0] rsel_q, fsel_q, imask_q, emask_q;
    logic [NLINES-1:0] lvl, rise, fall, rpend, fpend;
    logic [NLINES-1:0] sw_set, rclr, fclr;

    assign sw_set = (bus_wr && bus_addr == A_SWTRG) ? bus_wdata : '0;
    assign rclr   = (bus_wr && bus_addr == A_RPND)  ? bus_wdata : '0;
    assign fclr   = (bus_wr && bus_addr == A_FPND)  ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsel_q  <= '0;
            fsel_q  <= '0;
            imask_q <= '0;
            emask_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_RSEL) rsel_q  <= bus_wdata;
            if (bus_addr == A_FSEL) fsel_q  <= bus_wdata;
            if (bus_addr == A_IMSK) imask_q <= bus_wdata;
            if (bus_addr == A_EMSK) emask_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RSEL:  bus_rdata = rsel_q;
            A_FSEL:  bus_rdata = fsel_q;
            A_RPND:  bus_rdata = rpend;
            A_FPND:  bus_rdata = fpend;
            A_IMSK:  bus_rdata = imask_q;
            A_EMSK:  bus_rdata = emask_q;
            A_LTYPE: bus_rdata = EDGE_LINES;
            default: bus_rdata = '0;
        endcase
    end

    extint_sync #(.NLINES(NLINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    extint_pend #(.NLINES(NLINES), .EDGE_LINES(EDGE_LINES)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .fall_i  (fall),
        .rsel_i  (rsel_q),
        .fsel_i  (fsel_q),
        .sw_i    (sw_set),
        .rclr_i  (rclr),
        .fclr_i  (fclr),
        .emask_i (emask_q),
        .rpend_o (rpend),
        .fpend_o (fpend),
        .evt_o   (evt_o)
    );

    extint_irq_fsm #(.NLINES(NLINES), .EDGE_LINES(EDGE_LINES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rpend_i (rpend),
        .fpend_i (fpend),
        .imask_i (imask_q),
        .lvl_i   (lvl),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/extint_bank_chk.sv
`timescale 1ns/1ps
module extint_bank_chk
    import extint_pkg::*;
#(
    parameter int unsigned       NLINES     = 32,
    parameter int unsigned       ADDR_W     = 12,
    parameter logic [NLINES-1:0] EDGE_LINES = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NLINES-1:0] bus_wdata,
    input logic [NLINES-1:0] rpend,
    input logic [NLINES-1:0] fpend,
    input logic [NLINES-1:0] imask,
    input logic [NLINES-1:0] emask,
    input logic [NLINES-1:0] lvl,
    input logic              irq_o,
    input logic [NLINES-1:0] evt_o
);
    logic src, wr_sw, wr_rp, wr_fp;
    assign src   = |(((rpend | fpend) & imask) | (lvl & imask & ~EDGE_LINES));
    assign wr_sw = bus_wr && bus_addr == ADDR_W'(OFS_SWTRG);
    assign wr_rp = bus_wr && bus_addr == ADDR_W'(OFS_RPND);
    assign wr_fp = bus_wr && bus_addr == ADDR_W'(OFS_FPND);

    // R8
    irq_follows_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src |=> irq_o);

    // R11
    irq_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src |=> !irq_o);

    // R7
    swtrig_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sw |=> ((rpend & ($past(bus_wdata) & EDGE_LINES)) == ($past(bus_wdata) & EDGE_LINES)));

    // R5
    rpend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rp |=> ((rpend & $past(rpend)) == $past(rpend)));

    // R5
    fpend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fp |=> ((fpend & $past(fpend)) == $past(fpend)));

    // R9
    evt_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & ~$past(emask)) == '0));
endmodule

bind extint_bank extint_bank_chk #(
    .NLINES(NLINES), .ADDR_W(ADDR_W), .EDGE_LINES(EDGE_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rpend     (rpend),
    .fpend     (fpend),
    .imask     (imask_q),
    .emask     (emask_q),
    .lvl       (lvl),
    .irq_o     (irq_o),
    .evt_o     (evt_o)
);

// File: tb/extint_bank_bench.sv
`timescale 1ns/1ps
module extint_bank_bench;
    localparam logic [31:0] EDGE = 32'h0FFF_FFFF;
    localparam logic [11:0] RS = 12'h000, FS = 12'h004, SW = 12'h008, RP = 12'h00C,
                            FP = 12'h010, IM = 12'h080, EM = 12'h084, LT = 12'h3EC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line_i = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic [31:0] evt_o;

    int vectors = 0;
    int fails = 0;

    // behavioural reference state
    logic [31:0] m_rs = '0, m_fs = '0, m_im = '0, m_em = '0;
    logic [31:0] m_rp = '0, m_fp = '0, m_evt = '0;
    logic        m_irq = 1'b0;
    logic [31:0] hist[$] = '{32'h0, 32'h0, 32'h0};

    always #2 clk = ~clk;

    extint_bank u_extint_bank (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .evt_o(evt_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            RS: return m_rs;
            FS: return m_fs;
            RP: return m_rp;
            FP: return m_fp;
            IM: return m_im;
            EM: return m_em;
            LT: return EDGE;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [11:0] a);
        case (a)
            SW: return "R7 swtrig read";
            RP: return "R2 rpend read";
            FP: return "R3 fpend read";
            IM: return "R8 imask read";
            EM: return "R9 emask read";
            default: return "R12 register read";
        endcase
    endfunction

    task automatic model_step(input logic [31:0] l, input logic w, input logic [11:0] a,
                              input logic [31:0] d);
        logic [31:0] rise, fall, sw, rc, fc, setr, setf;
        logic        nirq;
        rise = hist[1] & ~hist[2];
        fall = ~hist[1] & hist[2];
        sw = (w && a == SW) ? d : 32'h0;
        rc = (w && a == RP) ? d : 32'h0;
        fc = (w && a == FP) ? d : 32'h0;
        setr = ((rise & m_rs) | sw) & EDGE;
        setf = (fall & m_fs) & EDGE;
        nirq = |(((m_rp | m_fp) & m_im) | (hist[1] & m_im & ~EDGE));
        m_evt = (setr | setf) & m_em;
        m_rp = (m_rp & ~rc) | setr;
        m_fp = (m_fp & ~fc) | setf;
        m_irq = nirq;
        if (w && a == RS) m_rs = d;
        if (w && a == FS) m_fs = d;
        if (w && a == IM) m_im = d;
        if (w && a == EM) m_em = d;
        hist.push_front(l);
        void'(hist.pop_back());
    endtask

    task automatic tick(input logic [31:0] l, input logic w, input logic [11:0] a,
                        input logic [31:0] d);
        @(negedge clk);
        line_i = l; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_step(l, w, a, d);
        #1;
        chk("R11 irq_o vs model", {31'h0, irq_o}, {31'h0, m_irq});
        chk("R9 evt_o vs model", evt_o, m_evt);
        chk(rd_tag(a), bus_rdata, exp_rd(a));
    endtask

    task automatic rd(input logic [31:0] l, input logic [11:0] a);
        tick(l, 1'b0, a, 32'h0);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] l;
        logic [11:0] offs[8] = '{RS, FS, SW, RP, FP, IM, EM, LT};
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        #1;
        chk("R1 irq_o after reset", {31'h0, irq_o}, 32'h0);
        chk("R1 evt_o after reset", evt_o, 32'h0);
        for (int k = 0; k < 8; k++) begin
            rd(32'h0, offs[k]);
            chk("R1 reset read", bus_rdata, (offs[k] == LT) ? EDGE : 32'h0);
        end

        // configuration
        tick(32'h0, 1'b1, RS, 32'h0000_00FF);
        tick(32'h0, 1'b1, FS, 32'h0000_F0F0);
        tick(32'h0, 1'b1, EM, 32'h0000_000F);
        rd(32'h0, RS);
        chk("R12 rsel readback", bus_rdata, 32'h0000_00FF);

        // R2: line 0 rising
        l = 32'h1;
        repeat (5) rd(l, RP);
        chk("R2 rising latched", bus_rdata, 32'h1);

        // R3: line 4 has both selects
        l = 32'h11;
        repeat (5) rd(l, FP);
        chk("R3 fpend after rise", bus_rdata, 32'h0);
        l = 32'h01;
        repeat (5) rd(l, RP);
        chk("R3 rpend both edges", bus_rdata, 32'h11);
        rd(l, FP);
        chk("R3 fpend after fall", bus_rdata, 32'h10);

        // R4: line 8 has no select
        l = 32'h101;
        repeat (5) rd(l, RP);
        l = 32'h001;
        repeat (5) rd(l, RP);
        chk("R4 unselected rpend", bus_rdata, 32'h11);
        rd(l, FP);
        chk("R4 unselected fpend", bus_rdata, 32'h10);

        // R5: write-one clear, zero write no effect
        tick(l, 1'b1, RP, 32'h1);
        chk("R5 clear bit0", bus_rdata, 32'h10);
        tick(l, 1'b1, FP, 32'h0);
        chk("R5 zero write keeps", bus_rdata, 32'h10);

        // R7: software trigger, direct bit 31 ignored
        tick(l, 1'b1, SW, 32'h8000_0200);
        chk("R7 swtrig reads zero", bus_rdata, 32'h0);
        rd(l, RP);
        chk("R7 swtrig sets rpend", bus_rdata, 32'h210);

        // R8: masked pending does not raise irq
        chk("R8 masked no irq", {31'h0, irq_o}, 32'h0);
        tick(l, 1'b1, IM, 32'h0000_0200);
        rd(l, RP);
        chk("R8 unmasked irq", {31'h0, irq_o}, 32'h1);
        tick(l, 1'b1, RP, 32'h210);
        rd(l, RP);
        chk("R11 irq falls", {31'h0, irq_o}, 32'h0);

        // R9: event pulse for software trigger on bit 2
        tick(l, 1'b1, SW, 32'h4);
        chk("R9 event pulse", evt_o, 32'h4);
        rd(l, RP);
        chk("R9 pulse one clock", evt_o, 32'h0);
        tick(l, 1'b1, RP, 32'h4);

        // R6: edge on line 3 coinciding with clear
        l = 32'h9;
        tick(l, 1'b0, RP, 32'h0);
        tick(l, 1'b0, RP, 32'h0);
        tick(l, 1'b1, RP, 32'h8);
        chk("R6 edge wins over clear", bus_rdata & 32'h8, 32'h8);

        // R10: direct line 28
        tick(l, 1'b1, IM, 32'h1000_0000);
        l = l | 32'h1000_0000;
        repeat (4) rd(l, RP);
        chk("R10 direct irq", {31'h0, irq_o}, 32'h1);
        chk("R10 direct no pending", bus_rdata & 32'hF000_0000, 32'h0);
        l = l & ~32'h1000_0000;
        repeat (4) rd(l, FP);
        chk("R10 direct irq clears", {31'h0, irq_o}, 32'h0);

        // R12: line-type is read only, unmapped reads zero
        tick(l, 1'b1, LT, 32'h0);
        rd(l, LT);
        chk("R12 line-type unchanged", bus_rdata, EDGE);
        rd(l, 12'h200);
        chk("R12 unmapped zero", bus_rdata, 32'h0);

        // random traffic, including edge/clear collisions (R6)
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(3, 0) == 0) l = l ^ (32'h1 << $urandom_range(31, 0));
            if ($urandom_range(3, 0) == 0)
                tick(l, 1'b1, offs[$urandom_range(7, 0)], $urandom);
            else
                rd(l, offs[$urandom_range(7, 0)]);
        end

        summary();
        $finish;
    end
endmodule